// File: doc/BRIEF.md
# Dual-Phase Wordclock Divider

This block divides a fast oscillator clock, running at 256 times the wordclock rate, into two wordclocks of equal frequency and 50% duty cycle. The first is a feedback wordclock. It goes only to an external phase-frequency detector and is never brought out for use elsewhere. The second is a distribution wordclock that lags the feedback clock by exactly 1/128 of a wordclock period, which is two oscillator cycles. In lock, the loop holds the feedback clock ahead of the reference by that same amount. The distribution clock therefore lines up with the reference, and the detector never has to work at zero phase error, where it is nonlinear.

Both clocks are derived from one free-running 8-bit phase counter. They are not produced by an asynchronous delay element. A small state machine tracks which quarter of the waveform pair the counter is in, and both outputs come from registers, so they change only on oscillator edges. The counter value is exported so that a lock monitor can sample phase positions. The machine has five states:

- WS_IDLE: after reset, both clocks low.
- WS_LEAD: feedback high, distribution low.
- WS_BOTH_HI: both high.
- WS_TRAIL: feedback low, distribution high.
- WS_BOTH_LO: both low.

It moves through them on these transitions:

- WS_IDLE to WS_LEAD on the first enabled cycle.
- WS_LEAD to WS_BOTH_HI when the count is 2.
- WS_BOTH_HI to WS_TRAIL when the count is 128.
- WS_TRAIL to WS_BOTH_LO when the count is 130.
- WS_BOTH_LO to WS_LEAD when the count is 0.

Every state holds while enable is low.

Top module: `wclk_dual_divider`

## Requirements
- R1: While the synchronous reset is high at a clock edge, the block sets phase_cnt to 0 and drives fb_wclk and dist_wclk low after that edge.
- R2: On each edge with en high and reset low, phase_cnt advances by one and wraps from 255 to 0.
- R3: On an edge with en low, phase_cnt, fb_wclk and dist_wclk all keep their values.
- R4: fb_wclk is 1 exactly when (phase_cnt - 1) mod 256 is below 128, giving a 256-cycle period with 128 cycles high.
- R5: dist_wclk is 1 exactly when (phase_cnt - 3) mod 256 is below 128, so it is a copy of fb_wclk delayed by two enabled oscillator cycles (1/128 of the period).
- R6: After reset is released with en high, fb_wclk rises on the first edge and dist_wclk rises on the third edge.
- R7: fb_wclk and dist_wclk never change on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock, 256 times the wordclock rate |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; when low, all state holds |
| fb_wclk | output | 1 | Feedback wordclock, for the phase detector only |
| dist_wclk | output | 1 | Distribution wordclock, two oscillator cycles behind the feedback clock |
| phase_cnt | output | 8 | Current phase counter value |

## Verification
A counter that slips or fails to hold appears at phase_cnt on the very next edge. It also breaks the fixed relation between the count and each wordclock within one cycle. If the state machine falls out of step with the counter, at least one wordclock sits at the wrong level against phase_cnt on the following edge. If the offset is wrong, dist_wclk rises or falls at the wrong count. The bench compares both clocks with a bench-side model of the count on every cycle, so each of these faults is reported within one oscillator cycle of the edge where it occurs.

// File: rtl/wclk_pkg.sv
package wclk_pkg;
    typedef enum logic [2:0] {
        WS_IDLE,
        WS_LEAD,
        WS_BOTH_HI,
        WS_TRAIL,
        WS_BOTH_LO
    } wclk_state_e;
endpackage

// File: rtl/wclk_phase_counter.sv
module wclk_phase_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (en)
            cnt_q <= cnt_q + ONE;
    end

    assign cnt = cnt_q;

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> (cnt_q == $past(cnt_q) + ONE) || $past(rst));

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt_q) || $past(rst));
endmodule

// File: rtl/wclk_phase_fsm.sv
module wclk_phase_fsm
    import wclk_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int OFFSET = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] cnt,
    output logic             fb_o,
    output logic             dist_o
);
    localparam logic [CNT_W-1:0] ZERO_V  = '0;
    localparam logic [CNT_W-1:0] OFF_V   = CNT_W'(OFFSET);
    localparam logic [CNT_W-1:0] HALF_V  = CNT_W'(2 ** (CNT_W - 1));
    localparam logic [CNT_W-1:0] TRAIL_V = CNT_W'(2 ** (CNT_W - 1) + OFFSET);

    wclk_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:    if (en)                    state_d = WS_LEAD;
            WS_LEAD:    if (en && cnt == OFF_V)    state_d = WS_BOTH_HI;
            WS_BOTH_HI: if (en && cnt == HALF_V)   state_d = WS_TRAIL;
            WS_TRAIL:   if (en && cnt == TRAIL_V)  state_d = WS_BOTH_LO;
            WS_BOTH_LO: if (en && cnt == ZERO_V)   state_d = WS_LEAD;
            default:                               state_d = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= WS_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fb_o   <= 1'b0;
            dist_o <= 1'b0;
        end else begin
            fb_o   <= (state_d == WS_LEAD)    || (state_d == WS_BOTH_HI);
            dist_o <= (state_d == WS_BOTH_HI) || (state_d == WS_TRAIL);
        end
    end

    // R6
    idle_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == WS_IDLE && en) |=> (fb_o && !dist_o));
endmodule

// File: rtl/wclk_dual_divider.sv
module wclk_dual_divider #(
    parameter int CNT_W  = 8,
    parameter int OFFSET = 2
) (
    input  logic             clk_osc,
    input  logic             rst,
    input  logic             en,
    output logic             fb_wclk,
    output logic             dist_wclk,
    output logic [CNT_W-1:0] phase_cnt
);
    localparam logic [CNT_W-1:0] HALF_V  = CNT_W'(2 ** (CNT_W - 1));
    localparam logic [CNT_W-1:0] FB_LAG  = CNT_W'(1);
    localparam logic [CNT_W-1:0] DS_LAG  = CNT_W'(1 + OFFSET);

    logic [CNT_W-1:0] cnt;

    wclk_phase_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk (clk_osc),
        .rst (rst),
        .en  (en),
        .cnt (cnt)
    );

    wclk_phase_fsm #(.CNT_W(CNT_W), .OFFSET(OFFSET)) i_fsm (
        .clk    (clk_osc),
        .rst    (rst),
        .en     (en),
        .cnt    (cnt),
        .fb_o   (fb_wclk),
        .dist_o (dist_wclk)
    );

    assign phase_cnt = cnt;

    // R4
    fb_phase_chk: assert property (@(posedge clk_osc) disable iff (rst)
        fb_wclk == ((cnt - FB_LAG) < HALF_V));

    // R5
    dist_phase_chk: assert property (@(posedge clk_osc) disable iff (rst)
        dist_wclk == ((cnt - DS_LAG) < HALF_V));

    // R7
    no_joint_toggle_chk: assert property (@(posedge clk_osc) disable iff (rst)
        !$stable(fb_wclk) |-> $stable(dist_wclk));

    // R3
    out_hold_chk: assert property (@(posedge clk_osc) disable iff (rst)
        (!en && !$past(rst)) |=> ($stable(fb_wclk) && $stable(dist_wclk)));
endmodule

// File: tb/test_wclk_dual_divider.sv
module test_wclk_dual_divider;
    logic       clk_osc = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       fb_wclk, dist_wclk;
    logic [7:0] phase_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] exp_cnt = 8'd0;
    logic       prev_fb = 1'b0;
    logic       prev_ds = 1'b0;

    always #10 clk_osc = ~clk_osc;

    wclk_dual_divider i_wclk_dual_divider (
        .clk_osc   (clk_osc),
        .rst       (rst),
        .en        (en),
        .fb_wclk   (fb_wclk),
        .dist_wclk (dist_wclk),
        .phase_cnt (phase_cnt)
    );

    // {en, cycle count}
    localparam logic [10:0] VEC [6] = '{
        {1'b1, 10'd100}, {1'b0, 10'd5},   {1'b1, 10'd200},
        {1'b0, 10'd3},   {1'b1, 10'd300}, {1'b1, 10'd1}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R2/R3 count", phase_cnt, exp_cnt);
        chk("R4 fb_wclk", {7'd0, fb_wclk}, {7'd0, ((exp_cnt - 8'd1) < 8'd128)});
        chk("R5 dist_wclk", {7'd0, dist_wclk}, {7'd0, ((exp_cnt - 8'd3) < 8'd128)});
        chk("R7 joint toggle", {7'd0, (fb_wclk != prev_fb) && (dist_wclk != prev_ds)}, 8'd0);
        prev_fb = fb_wclk;
        prev_ds = dist_wclk;
    endtask

    task automatic step(input logic en_v);
        en = en_v;
        @(posedge clk_osc);
        if (en_v) exp_cnt = exp_cnt + 8'd1;
        @(negedge clk_osc);
        check_all();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        en = 1'b1;
        @(posedge clk_osc);
        @(negedge clk_osc);
        rst = 1'b0;
        exp_cnt = 8'd0;
        // R1
        chk("R1 count", phase_cnt, 8'd0);
        chk("R1 fb", {7'd0, fb_wclk}, 8'd0);
        chk("R1 dist", {7'd0, dist_wclk}, 8'd0);
        prev_fb = fb_wclk;
        prev_ds = dist_wclk;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk_osc);
        @(negedge clk_osc);
        do_reset();

        // R6: first edges after release
        step(1'b1);
        chk("R6 fb first edge", {7'd0, fb_wclk}, 8'd1);
        chk("R6 dist first edge", {7'd0, dist_wclk}, 8'd0);
        step(1'b1);
        chk("R6 dist second edge", {7'd0, dist_wclk}, 8'd0);
        step(1'b1);
        chk("R6 dist third edge", {7'd0, dist_wclk}, 8'd1);

        // table walk covering R2 wrap, R3 holds, R4, R5, R7
        foreach (VEC[i]) begin
            for (int n = 0; n < int'(VEC[i][9:0]); n++)
                step(VEC[i][10]);
        end

        // R3: hold right at a falling point of fb (count 129)
        while (exp_cnt != 8'd129) step(1'b1);
        for (int n = 0; n < 4; n++) begin
            step(1'b0);
            chk("R3 fb held", {7'd0, fb_wclk}, 8'd0);
            chk("R3 dist held", {7'd0, dist_wclk}, 8'd1);
        end

        // R1: reset in mid-run
        do_reset();
        for (int n = 0; n < 260; n++) step(1'b1);

        finish_run();
    end
endmodule